// File: doc/BRIEF.md
# Processor mode and saved-status registers

This block keeps a processor's live status word and a saved copy of it that is used while exceptions are handled. The pipeline signals what happens in each cycle: an external interrupt, a nonbreak exception, a break, or a return from exception. The block then updates both words. It clears the interrupt-enable and user bits, marks the core as being in exception-handler mode, and saves the previous status where the rules allow.

A CSR port reads and writes either word. Fields whose hardware option is absent are tied to zero. An interrupt that asks for a shadow register set hands its status snapshot to a separate output instead of the saved copy. Software writes that would put the core in the undefined state with handler mode and user mode both set are flagged, and the written value is still stored.

Top module: `cpu_mode_regs`

## Requirements
- R1: Synchronous active-high reset clears both words, the shadow snapshot, read data, all mode outputs, `sstatus_vld` and `wr_illegal`.
- R2: A CSR write stores the masked write data into status (`csr_addr`=0) or the saved copy (`csr_addr`=1). The field layout is: bit 0 interrupt enable, bit 1 user, bit 2 handler mode, bit 3 interrupt-handler, 9:4 interrupt level, 15:10 current register set, 21:16 previous register set, bit 22 non-maskable flag, bit 23 register-set interrupt enable. Bits 31:24 are always zero. `csr_rdata` is registered and shows, one cycle later, the word selected by `csr_addr`.
- R3: Bits of absent options read as zero and ignore writes. The user bit needs the MMU or MPU option, the handler bit needs MMU or ECC, bit 3, 9:4 and bit 22 need the interrupt-controller option, and 15:10, 21:16 and bit 23 need the shadow-set option.
- R4: `ev_irq` is ignored while status bit 0 is 0.
- R5: An accepted interrupt sets bits 3 and 2 and clears bits 0 and 1 of status.
- R6: `ev_exc` and `ev_brk` set bit 2 and clear bits 0 and 1, whatever the value of bit 0.
- R7: An accepted interrupt without a shadow request, and a nonbreak exception, copy the old status into the saved copy only when the old bit 2 is 0. A break never updates the saved copy.
- R8: With the shadow-set option, an accepted interrupt with `irq_shadow` high copies the old status to `sstatus`, pulses `sstatus_vld` for one cycle, and leaves the saved copy unchanged.
- R9: `ev_eret` loads status from the saved copy in one cycle.
- R10: Priority from highest to lowest is: accepted interrupt, exception, break, return, CSR write. A lower-priority request in the same cycle is dropped.
- R11: An applied CSR write whose masked data has bits 1 and 2 both set pulses `wr_illegal` for one cycle, and the value is still stored.
- R12: `mode_pie`, `mode_user` and `mode_eh` equal status bits 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 1 | 0 selects status, 1 selects the saved copy |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | Registered CSR read data |
| ev_irq | input | 1 | External interrupt taken |
| irq_shadow | input | 1 | Interrupt requests a shadow register set |
| ev_exc | input | 1 | Nonbreak exception taken |
| ev_brk | input | 1 | Break taken |
| ev_eret | input | 1 | Return from exception |
| mode_user | output | 1 | User mode (status bit 1) |
| mode_pie | output | 1 | Interrupt enable (status bit 0) |
| mode_eh | output | 1 | Exception-handler mode (status bit 2) |
| sstatus | output | 32 | Status snapshot for a shadow-set interrupt |
| sstatus_vld | output | 1 | One-cycle pulse when `sstatus` is loaded |
| wr_illegal | output | 1 | One-cycle flag for a write that sets user and handler bits together |

## Verification
The bench targets the following corner cases:
- A nested exception that arrives while handler mode is already set. A design that saved anyway would overwrite the first return context.
- A break. A design that treated it as a nonbreak exception would overwrite the saved copy.
- An interrupt while interrupts are disabled. A faulty design would take it and lose its live state.
- Simultaneous strobes. Wrong priority would let a CSR write or return survive an entry.
- A shadow-set interrupt that leaks into the saved copy.
- A reduced-option instance, where a write would otherwise bring fields to life that do not exist.

// File: rtl/cpu_mode_pkg.sv
package cpu_mode_pkg;

  localparam int REG_W   = 32;
  localparam int PIE_B   = 0;
  localparam int U_B     = 1;
  localparam int EH_B    = 2;
  localparam int IH_B    = 3;
  localparam int IL_LO   = 4;
  localparam int LVL_W   = 6;
  localparam int IL_HI   = IL_LO + LVL_W - 1;
  localparam int CRS_LO  = IL_HI + 1;
  localparam int SET_W   = 6;
  localparam int CRS_HI  = CRS_LO + SET_W - 1;
  localparam int PRS_LO  = CRS_HI + 1;
  localparam int PRS_HI  = PRS_LO + SET_W - 1;
  localparam int NMI_B   = PRS_HI + 1;
  localparam int RSIE_B  = NMI_B + 1;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_IRQ,
    ACT_EXC,
    ACT_BRK,
    ACT_ERET,
    ACT_WR_ST,
    ACT_WR_EST
  } mode_act_e;

  // Bits that exist for a given set of hardware options.
  function automatic logic [REG_W-1:0] impl_mask(input bit eic, input bit mmu,
                                                  input bit mpu, input bit ecc,
                                                  input bit shadow);
    logic [REG_W-1:0] m;
    m = '0;
    m[PIE_B] = 1'b1;
    if (mmu || mpu) m[U_B] = 1'b1;
    if (mmu || ecc) m[EH_B] = 1'b1;
    if (eic) begin
      m[IH_B]        = 1'b1;
      m[IL_HI:IL_LO] = '1;
      m[NMI_B]       = 1'b1;
    end
    if (shadow) begin
      m[CRS_HI:CRS_LO] = '1;
      m[PRS_HI:PRS_LO] = '1;
      m[RSIE_B]        = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/cpu_mode_ctrl.sv
module cpu_mode_ctrl
  import cpu_mode_pkg::*;
#(
  parameter bit SHADOW_ON = 1'b1
) (
  input  logic             ev_irq,
  input  logic             irq_shadow,
  input  logic             ev_exc,
  input  logic             ev_brk,
  input  logic             ev_eret,
  input  logic             csr_we,
  input  logic             csr_addr,
  input  logic             cur_pie,
  input  logic             cur_eh,
  input  logic             wr_u,
  input  logic             wr_eh,
  output mode_act_e        act,
  output logic             save_est,
  output logic             save_sst,
  output logic             illegal
);

  logic irq_ok;
  logic shadow_req;

  assign irq_ok     = ev_irq && cur_pie;
  assign shadow_req = irq_shadow && SHADOW_ON;

  always_comb begin
    if (irq_ok)       act = ACT_IRQ;
    else if (ev_exc)  act = ACT_EXC;
    else if (ev_brk)  act = ACT_BRK;
    else if (ev_eret) act = ACT_ERET;
    else if (csr_we)  act = csr_addr ? ACT_WR_EST : ACT_WR_ST;
    else              act = ACT_NONE;
  end

  assign save_sst = irq_ok && shadow_req;
  assign save_est = !cur_eh &&
                    (((act == ACT_IRQ) && !shadow_req) || (act == ACT_EXC));
  assign illegal  = ((act == ACT_WR_ST) || (act == ACT_WR_EST)) && wr_u && wr_eh;

endmodule

// File: rtl/cpu_mode_regfile.sv
module cpu_mode_regfile
  import cpu_mode_pkg::*;
#(
  parameter logic [REG_W-1:0] MASK = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  mode_act_e        act,
  input  logic             save_est,
  input  logic             save_sst,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] st_q,
  output logic [REG_W-1:0] est_q,
  output logic [REG_W-1:0] sst_q,
  output logic             sst_vld_q
);

  logic [REG_W-1:0] st_n;
  logic [REG_W-1:0] est_n;

  always_comb begin
    st_n  = st_q;
    est_n = est_q;
    case (act)
      ACT_IRQ, ACT_EXC, ACT_BRK: begin
        st_n[PIE_B] = 1'b0;
        st_n[U_B]   = 1'b0;
        st_n[EH_B]  = 1'b1;
        if (act == ACT_IRQ) st_n[IH_B] = 1'b1;
      end
      ACT_ERET:   st_n  = est_q;
      ACT_WR_ST:  st_n  = wdata;
      ACT_WR_EST: est_n = wdata;
      default: ;
    endcase
    if (save_est) est_n = st_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= '0;
      est_q     <= '0;
      sst_q     <= '0;
      sst_vld_q <= 1'b0;
    end else begin
      st_q      <= st_n & MASK;
      est_q     <= est_n & MASK;
      sst_vld_q <= save_sst;
      if (save_sst) sst_q <= st_q;
    end
  end

endmodule

// File: rtl/cpu_mode_regs.sv
module cpu_mode_regs
  import cpu_mode_pkg::*;
#(
  parameter bit HAS_EIC    = 1'b1,
  parameter bit HAS_MMU    = 1'b1,
  parameter bit HAS_MPU    = 1'b0,
  parameter bit HAS_ECC    = 1'b0,
  parameter bit HAS_SHADOW = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             csr_we,
  input  logic             csr_addr,
  input  logic [REG_W-1:0] csr_wdata,
  output logic [REG_W-1:0] csr_rdata,
  input  logic             ev_irq,
  input  logic             irq_shadow,
  input  logic             ev_exc,
  input  logic             ev_brk,
  input  logic             ev_eret,
  output logic             mode_user,
  output logic             mode_pie,
  output logic             mode_eh,
  output logic [REG_W-1:0] sstatus,
  output logic             sstatus_vld,
  output logic             wr_illegal
);

  localparam logic [REG_W-1:0] MASK = impl_mask(HAS_EIC, HAS_MMU, HAS_MPU,
                                                HAS_ECC, HAS_SHADOW);

  logic [REG_W-1:0] wmask;
  logic [REG_W-1:0] st_q, est_q;
  mode_act_e        act;
  logic             save_est, save_sst, illegal;
  logic             illegal_q;
  logic [REG_W-1:0] rdata_q;

  assign wmask = csr_wdata & MASK;

  cpu_mode_ctrl #(.SHADOW_ON(HAS_SHADOW)) u_ctrl (
    .ev_irq     (ev_irq),
    .irq_shadow (irq_shadow),
    .ev_exc     (ev_exc),
    .ev_brk     (ev_brk),
    .ev_eret    (ev_eret),
    .csr_we     (csr_we),
    .csr_addr   (csr_addr),
    .cur_pie    (st_q[PIE_B]),
    .cur_eh     (st_q[EH_B]),
    .wr_u       (wmask[U_B]),
    .wr_eh      (wmask[EH_B]),
    .act        (act),
    .save_est   (save_est),
    .save_sst   (save_sst),
    .illegal    (illegal)
  );

  cpu_mode_regfile #(.MASK(MASK)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .act       (act),
    .save_est  (save_est),
    .save_sst  (save_sst),
    .wdata     (wmask),
    .st_q      (st_q),
    .est_q     (est_q),
    .sst_q     (sstatus),
    .sst_vld_q (sstatus_vld)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q   <= '0;
      illegal_q <= 1'b0;
    end else begin
      rdata_q   <= csr_addr ? est_q : st_q;
      illegal_q <= illegal;
    end
  end

  assign csr_rdata  = rdata_q;
  assign wr_illegal = illegal_q;
  assign mode_pie   = st_q[PIE_B];
  assign mode_user  = st_q[U_B];
  assign mode_eh    = st_q[EH_B];

endmodule

// File: rtl/cpu_mode_regs_chk.sv
module cpu_mode_regs_chk #(
  parameter bit EH_IMPL = 1'b1
) (
  input logic        clk,
  input logic        rst,
  input logic        csr_we,
  input logic [31:0] csr_rdata,
  input logic        ev_irq,
  input logic        irq_shadow,
  input logic        ev_exc,
  input logic        ev_brk,
  input logic        ev_eret,
  input logic        mode_user,
  input logic        mode_pie,
  input logic        mode_eh,
  input logic        sstatus_vld,
  input logic        wr_illegal
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (csr_rdata == 32'd0) && !mode_pie && !mode_user && !mode_eh &&
            !sstatus_vld && !wr_illegal);

  assert_masked_irq_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (ev_irq && !mode_pie && !ev_exc && !ev_brk && !ev_eret && !csr_we)
      |=> $stable(mode_pie) && $stable(mode_user) && $stable(mode_eh));

  assert_irq_entry_R5: assert property (@(posedge clk) disable iff (rst)
    (ev_irq && mode_pie) |=> !mode_pie && !mode_user && (mode_eh == EH_IMPL));

  assert_exc_entry_R6: assert property (@(posedge clk) disable iff (rst)
    (ev_exc || ev_brk) |=> !mode_pie && !mode_user && (mode_eh == EH_IMPL));

  assert_shadow_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    sstatus_vld |-> $past(ev_irq && irq_shadow && mode_pie));

  assert_illegal_from_write_R11: assert property (@(posedge clk) disable iff (rst)
    wr_illegal |-> $past(csr_we && !ev_exc && !ev_brk && !ev_eret));

endmodule

bind cpu_mode_regs cpu_mode_regs_chk #(.EH_IMPL(HAS_MMU || HAS_ECC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .csr_we      (csr_we),
  .csr_rdata   (csr_rdata),
  .ev_irq      (ev_irq),
  .irq_shadow  (irq_shadow),
  .ev_exc      (ev_exc),
  .ev_brk      (ev_brk),
  .ev_eret     (ev_eret),
  .mode_user   (mode_user),
  .mode_pie    (mode_pie),
  .mode_eh     (mode_eh),
  .sstatus_vld (sstatus_vld),
  .wr_illegal  (wr_illegal)
);

// File: tb/cpu_mode_regs_test.sv
`timescale 1ns/1ps
module cpu_mode_regs_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_we = 1'b0, csr_addr = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic        ev_irq = 1'b0, irq_shadow = 1'b0, ev_exc = 1'b0;
  logic        ev_brk = 1'b0, ev_eret = 1'b0;

  logic [31:0] rd [2];
  logic [31:0] ss [2];
  logic        mu [2], mp [2], me [2], sv [2], il [2];

  // full-option instance
  cpu_mode_regs uut (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(rd[0]), .ev_irq(ev_irq),
    .irq_shadow(irq_shadow), .ev_exc(ev_exc), .ev_brk(ev_brk),
    .ev_eret(ev_eret), .mode_user(mu[0]), .mode_pie(mp[0]), .mode_eh(me[0]),
    .sstatus(ss[0]), .sstatus_vld(sv[0]), .wr_illegal(il[0]));

  // reduced instance: only interrupt enable, user and handler bits exist (R3)
  cpu_mode_regs #(.HAS_EIC(1'b0), .HAS_MMU(1'b1), .HAS_MPU(1'b0),
                  .HAS_ECC(1'b0), .HAS_SHADOW(1'b0)) uut_lite (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(rd[1]), .ev_irq(ev_irq),
    .irq_shadow(irq_shadow), .ev_exc(ev_exc), .ev_brk(ev_brk),
    .ev_eret(ev_eret), .mode_user(mu[1]), .mode_pie(mp[1]), .mode_eh(me[1]),
    .sstatus(ss[1]), .sstatus_vld(sv[1]), .wr_illegal(il[1]));

  always #2 clk = ~clk;

  localparam logic [31:0] MASK_FULL = 32'h00FF_FFFF;
  localparam logic [31:0] MASK_LITE = 32'h0000_0007;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] m_st [2], m_est [2], m_sst [2], e_rd [2];
  logic        e_sv [2], e_ill [2];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    for (int k = 0; k < 2; k++) begin
      string n;
      n = (k == 0) ? "full" : "R3 lite";
      chk({"R2 read data ", n}, rd[k], e_rd[k]);
      chk({"R12 mode bits ", n}, {29'd0, me[k], mu[k], mp[k]}, {29'd0, m_st[k][2:0]});
      chk({"R8 shadow snapshot ", n}, {ss[k][30:0], sv[k]}, {m_sst[k][30:0], e_sv[k]});
      chk({"R11 illegal flag ", n}, {31'd0, il[k]}, {31'd0, e_ill[k]});
    end
  endtask

  function automatic void step(int k, logic [31:0] mask, bit shd_on);
    logic [31:0] st, est, wm, nst;
    bit irq_ok, shd;
    st = m_st[k]; est = m_est[k]; wm = csr_wdata & mask;
    e_rd[k] = csr_addr ? est : st;
    irq_ok = ev_irq && st[0];
    shd = shd_on && irq_shadow;
    e_sv[k] = irq_ok && shd;
    e_ill[k] = 1'b0;
    nst = st; nst[0] = 1'b0; nst[1] = 1'b0; nst[2] = 1'b1;
    if (irq_ok) begin
      nst[3] = 1'b1;
      if (shd) m_sst[k] = st;
      else if (!st[2]) m_est[k] = st;
      m_st[k] = nst & mask;
    end else if (ev_exc) begin
      if (!st[2]) m_est[k] = st;
      m_st[k] = nst & mask;
    end else if (ev_brk) begin
      m_st[k] = nst & mask;
    end else if (ev_eret) begin
      m_st[k] = est;
    end else if (csr_we) begin
      e_ill[k] = wm[1] && wm[2];
      if (csr_addr) m_est[k] = wm; else m_st[k] = wm;
    end
  endfunction

  task automatic cyc(input bit irq, input bit shd, input bit exc, input bit brk,
                     input bit eret, input bit we, input bit addr, input logic [31:0] wd);
    @(negedge clk);
    check_all();
    ev_irq = irq; irq_shadow = shd; ev_exc = exc; ev_brk = brk; ev_eret = eret;
    csr_we = we; csr_addr = addr; csr_wdata = wd;
    step(0, MASK_FULL, 1'b1);
    step(1, MASK_LITE, 1'b0);
  endtask

  initial begin
    for (int k = 0; k < 2; k++) begin
      m_st[k] = '0; m_est[k] = '0; m_sst[k] = '0; e_rd[k] = '0;
      e_sv[k] = 1'b0; e_ill[k] = 1'b0;
    end
    void'($urandom(32'd20417));
    repeat (3) @(negedge clk);
    check_all();                               // R1 reset state
    rst = 1'b0;
    cyc(0,0,0,0,0, 1,0, 32'h0000_0001);        // R2 enable interrupts
    cyc(0,0,0,0,0, 0,0, 32'h0);
    cyc(1,0,0,0,0, 0,0, 32'h0);                // R5 R7 interrupt saves status
    cyc(0,0,0,0,0, 0,1, 32'h0);
    cyc(1,0,0,0,0, 0,1, 32'h0);                // R4 masked interrupt ignored
    cyc(0,0,1,0,0, 0,1, 32'h0);                // R6 R7 nested exception, no save
    cyc(0,0,0,0,1, 0,1, 32'h0);                // R9 return restores
    cyc(0,0,0,0,0, 1,1, 32'hFFFF_FFFF);        // R2 R3 high bits dropped
    cyc(0,0,0,0,0, 0,1, 32'h0);
    cyc(0,0,0,0,0, 1,0, 32'h0055_AA01);
    cyc(1,1,0,0,0, 0,1, 32'h0);                // R8 shadow request
    cyc(0,0,0,0,0, 1,0, 32'h0000_0011);
    cyc(0,0,0,1,0, 0,1, 32'h0);                // R7 break leaves saved copy
    cyc(0,0,0,0,0, 1,0, 32'h0000_0006);        // R11 illegal combination
    cyc(0,0,0,0,0, 1,0, 32'h0000_0001);
    cyc(1,0,1,1,1, 1,0, 32'h0000_0006);        // R10 interrupt wins over all
    cyc(0,0,1,1,1, 1,1, 32'h0000_0003);        // R10 exception wins
    cyc(0,0,0,1,1, 1,0, 32'h0000_0003);        // R10 break wins
    cyc(0,0,0,0,1, 1,0, 32'h0000_0003);        // R10 return beats write
    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom % 6) == 0, $urandom % 2, ($urandom % 9) == 0,
          ($urandom % 13) == 0, ($urandom % 7) == 0, ($urandom % 3) == 0,
          $urandom % 2, (($urandom % 4) == 0) ? 32'h1 : $urandom);
    end
    cyc(0,0,0,0,0, 0,0, 32'h0);
    @(negedge clk);
    check_all();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule